// File: doc/BRIEF.md
# Dual Ratio-Programmed Pulse Generator

This block drives two independent pulse trains, one for each of two power switches. Each channel is set up with a pulse width in clock cycles and an integer ratio. The period of the channel is the ratio times the pulse width. Each period starts with the pulse, so the output is high for the first pulse-width cycles and low for the rest. A larger ratio therefore gives a lower average output. The block runs from a 50 MHz system clock.

Software writes settings through a simple write port. Each write lands in a shadow register. A channel copies its shadow values into its working registers only when its current period ends. A change of setting therefore never cuts a pulse short and never stretches one. An enable input stops both channels at once and restarts them together.

Each channel is a four-state machine:
- `CH_OFF`: disabled.
- `CH_HOLD`: the working width is zero and the output stays low.
- `CH_PULSE`: the high part of a period.
- `CH_REST`: the low part of a period.

The transitions are:
- *disable*: any state goes to `CH_OFF` while enable is low.
- *load*: taken from `CH_OFF` or `CH_HOLD` on any enabled cycle, and from `CH_PULSE` or `CH_REST` on the last cycle of a period. It copies the shadow values and goes to `CH_PULSE`, or to `CH_HOLD` if the new width is zero.
- *pulse-end*: `CH_PULSE` goes to `CH_REST` when the first width-long slot of the period finishes.
- *stay*: every other cycle keeps the current state.

Top module: `dual_pwm_top`

## Requirements
- R1: After reset both outputs are low. The shadow registers hold width 0 and ratio 1, so enabling without any write keeps both outputs low.
- R2: With width W > 0 and ratio N > 1 in force, the output is high for W cycles and then low for (N-1)*W cycles. This pattern repeats with period N*W.
- R3: A write updates only the shadow register. The running period finishes with the old settings, and the new values take effect from the next period start.
- R4: A ratio of 1 with a nonzero width keeps the output continuously high.
- R5: A width of 0 keeps the output low, and the channel reloads its shadow values on every cycle. A written ratio of 0 is treated as 1.
- R6: While enable is low, both outputs are low one cycle later. On the first clock edge with enable high, each channel loads its shadow values and starts a fresh period, with its output high from that edge when the width is nonzero.
- R7: The channels are independent. wr_addr bit 1 selects the channel (0 = channel A, 1 = channel B). wr_addr bit 0 selects the field (0 = width, 1 = ratio). The field value is the low bits of wr_data.
- R8: With channel A at width 250 and ratio 150 (a 37500-cycle period) and channel B at width 5000 and ratio 5 (a 25000-cycle period), a 75000-cycle window holds exactly 500 high cycles on A and 15000 on B.
- R9: Ratios up to 10000 are supported. Width 2 with ratio 10000 gives a 20000-cycle period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs both channels when high; forces both outputs low when low |
| wr_en | input | 1 | Write strobe for the shadow registers |
| wr_addr | input | 2 | Bit 1 selects the channel, bit 0 selects width (0) or ratio (1) |
| wr_data | input | DATA_W (16) | Value written to the selected field |
| pwm_a | output | 1 | Registered pulse output of channel A |
| pwm_b | output | 1 | Registered pulse output of channel B |

## Verification
A wrong slot or sub-slot count shows at the pin within one period: a pulse comes out too long or too short, or a period ends early. A shadow value copied into the working registers at the wrong time shows as a period whose length matches neither the old nor the new setting. The bench compares each output on every cycle against a reference model that tracks period position. Any such fault is therefore caught on the first cycle where the output differs, at most one period after the error occurs.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
    typedef enum logic [1:0] {
        CH_OFF,
        CH_HOLD,
        CH_PULSE,
        CH_REST
    } ch_state_t;
endpackage

// File: rtl/dpwm_shadow_regs.sv
module dpwm_shadow_regs #(
    parameter int NCH     = 2,
    parameter int WIDTH_W = 16,
    parameter int RATIO_W = 14,
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [WIDTH_W-1:0] sh_w [NCH],
    output logic [RATIO_W-1:0] sh_r [NCH]
);
    localparam int SEL_W = ADDR_W - 1;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit;
        assign hit = wr_en && (wr_addr[ADDR_W-1:1] == SEL_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_w[g] <= '0;
                sh_r[g] <= RATIO_W'(1);
            end else if (hit) begin
                if (wr_addr[0]) begin
                    sh_r[g] <= wr_data[RATIO_W-1:0];
                end else begin
                    sh_w[g] <= wr_data[WIDTH_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/dpwm_channel.sv
module dpwm_channel
    import dpwm_pkg::*;
#(
    parameter int WIDTH_W = 16,
    parameter int RATIO_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [WIDTH_W-1:0] sh_w,
    input  logic [RATIO_W-1:0] sh_r,
    output logic               pwm
);
    ch_state_t          state, nxt_state;
    logic [WIDTH_W-1:0] sub, nxt_sub;
    logic [RATIO_W-1:0] slot, nxt_slot;
    logic [WIDTH_W-1:0] act_w;
    logic [RATIO_W-1:0] act_r;
    logic [RATIO_W-1:0] ld_r;
    logic               sub_end;
    logic               last;
    logic               load;
    logic               pwm_q;

    // A written ratio of 0 behaves as 1.
    assign ld_r    = (sh_r == '0) ? RATIO_W'(1) : sh_r;
    assign sub_end = (sub == act_w - WIDTH_W'(1));
    assign last    = (state == CH_OFF) || (state == CH_HOLD) ||
                     (sub_end && (slot == act_r - RATIO_W'(1)));

    always_comb begin
        nxt_state = state;
        nxt_sub   = sub;
        nxt_slot  = slot;
        load      = 1'b0;
        if (!enable) begin
            nxt_state = CH_OFF;
            nxt_sub   = '0;
            nxt_slot  = '0;
        end else begin
            unique case (state)
                CH_OFF, CH_HOLD: begin
                    load = 1'b1;
                end
                CH_PULSE, CH_REST: begin
                    if (last) begin
                        load = 1'b1;
                    end else if (sub_end) begin
                        nxt_sub   = '0;
                        nxt_slot  = slot + RATIO_W'(1);
                        nxt_state = CH_REST;
                    end else begin
                        nxt_sub = sub + WIDTH_W'(1);
                    end
                end
            endcase
            if (load) begin
                nxt_sub   = '0;
                nxt_slot  = '0;
                nxt_state = (sh_w == '0) ? CH_HOLD : CH_PULSE;
            end
        end
    end

    // State and counter register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CH_OFF;
            sub   <= '0;
            slot  <= '0;
            act_w <= '0;
            act_r <= RATIO_W'(1);
        end else begin
            state <= nxt_state;
            sub   <= nxt_sub;
            slot  <= nxt_slot;
            if (load) begin
                act_w <= sh_w;
                act_r <= ld_r;
            end
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_q <= 1'b0;
        end else begin
            pwm_q <= (nxt_state == CH_PULSE);
        end
    end

    assign pwm = pwm_q;
endmodule

// File: rtl/dual_pwm_top.sv
module dual_pwm_top #(
    parameter int WIDTH_W = 16,
    parameter int RATIO_W = 14,
    parameter int DATA_W  = (WIDTH_W > RATIO_W) ? WIDTH_W : RATIO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_a,
    output logic              pwm_b
);
    localparam int NCH    = 2;
    localparam int ADDR_W = $clog2(NCH) + 1;

    logic [WIDTH_W-1:0] sh_w [NCH];
    logic [RATIO_W-1:0] sh_r [NCH];
    logic [NCH-1:0]     pwm_vec;

    dpwm_shadow_regs #(
        .NCH(NCH), .WIDTH_W(WIDTH_W), .RATIO_W(RATIO_W),
        .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .sh_w(sh_w), .sh_r(sh_r)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        dpwm_channel #(.WIDTH_W(WIDTH_W), .RATIO_W(RATIO_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .enable(enable),
            .sh_w(sh_w[g]), .sh_r(sh_r[g]), .pwm(pwm_vec[g])
        );
    end

    assign pwm_a = pwm_vec[0];
    assign pwm_b = pwm_vec[1];
endmodule

// File: rtl/dpwm_channel_checker.sv
module dpwm_channel_checker
    import dpwm_pkg::*;
#(
    parameter int WIDTH_W = 16,
    parameter int RATIO_W = 14
) (
    input logic               clk,
    input logic               rst_n,
    input logic               enable,
    input logic               pwm,
    input ch_state_t          state,
    input logic [WIDTH_W-1:0] act_w,
    input logic [RATIO_W-1:0] act_r,
    input logic               last
);
    assert_off_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pwm);

    assert_zero_width_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_w == '0) |-> !pwm);

    assert_ratio_one_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != CH_OFF && act_r == RATIO_W'(1) && act_w != '0) |-> pwm);

    assert_settings_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> ($stable(act_w) && $stable(act_r)));

    assert_ratio_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        act_r != '0);
endmodule

bind dpwm_channel dpwm_channel_checker #(.WIDTH_W(WIDTH_W), .RATIO_W(RATIO_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pwm(pwm),
    .state(state), .act_w(act_w), .act_r(act_r), .last(last)
);

// File: tb/dual_pwm_top_test.sv
`timescale 1ns/1ps
module dual_pwm_top_test;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_a, pwm_b;

    int tests = 0;
    int fails = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    // Reference model state per channel.
    int  m_sw [2];
    int  m_sr [2];
    int  m_w  [2];
    int  m_r  [2];
    int  m_pos[2];
    bit  m_off[2];
    bit  m_out[2];

    dual_pwm_top uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    always #(CLK_NS/2) clk = ~clk;

    function automatic int eff_ratio(int r);
        return (r == 0) ? 1 : r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_sw[c] = 0; m_sr[c] = 1; m_w[c] = 0; m_r[c] = 1;
                m_pos[c] = 0; m_off[c] = 1; m_out[c] = 0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                if (!enable) begin
                    m_off[c] = 1; m_out[c] = 0;
                end else if (m_off[c] || m_w[c] == 0 || m_pos[c] == m_w[c] * m_r[c] - 1) begin
                    m_w[c] = m_sw[c]; m_r[c] = eff_ratio(m_sr[c]);
                    m_pos[c] = 0; m_off[c] = 0; m_out[c] = (m_w[c] != 0);
                end else begin
                    m_pos[c] = m_pos[c] + 1;
                    m_out[c] = (m_pos[c] < m_w[c]);
                end
            end
            if (wr_en) begin
                if (wr_addr[0]) m_sr[wr_addr[1]] = int'(wr_data[13:0]);
                else            m_sw[wr_addr[1]] = int'(wr_data);
            end
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (!done) begin
            tests += 2;
            if (pwm_a !== m_out[0]) begin
                fails++;
                $display("FAIL %s pwm_a actual=%b expected=%b t=%0t", cur_req, pwm_a, m_out[0], $time);
            end
            if (pwm_b !== m_out[1]) begin
                fails++;
                $display("FAIL %s pwm_b actual=%b expected=%b t=%0t", cur_req, pwm_b, m_out[1], $time);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int ch, input bit fld, input int val);
        wr_en = 1'b1; wr_addr = {ch[0], fld}; wr_data = 16'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic count_high(input int n, output int ha, output int hb);
        ha = 0; hb = 0;
        repeat (n) begin
            @(negedge clk);
            ha += int'(pwm_a); hb += int'(pwm_b);
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        $display("FAIL watchdog expired during %s", cur_req);
        fails++;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int ha, hb;
        void'($urandom(32'd20240611));
        cyc(3);
        check(pwm_a == 0 && pwm_b == 0, "R1 reset low", int'(pwm_a) + int'(pwm_b), 0);
        rst_n = 1'b1;
        cyc(2);
        // R1: defaults keep outputs low even when enabled.
        enable = 1'b1;
        count_high(20, ha, hb);
        check(ha == 0 && hb == 0, "R1 default shadow", ha + hb, 0);

        // R2: basic pattern, width 3 ratio 4 on A, width 2 ratio 3 on B.
        cur_req = "R2";
        enable = 1'b0;
        wr(0, 0, 3); wr(0, 1, 4); wr(1, 0, 2); wr(1, 1, 3);
        enable = 1'b1;
        count_high(36, ha, hb);
        check(ha == 9, "R2 A highs in 36", ha, 9);
        check(hb == 12, "R2 B highs in 36", hb, 12);

        // R3: mid-period write, current period must complete unchanged.
        cur_req = "R3";
        enable = 1'b0;
        wr(0, 0, 4); wr(0, 1, 3);
        enable = 1'b1;
        cyc(5);
        wr(0, 0, 8);
        count_high(6, ha, hb);
        check(ha == 0, "R3 old period kept", ha, 0);
        count_high(8, ha, hb);
        check(ha == 8, "R3 new width at boundary", ha, 8);
        cyc(40);

        // R4: ratio 1 gives continuous high.
        cur_req = "R4";
        wr(1, 0, 5); wr(1, 1, 1);
        cyc(30);
        count_high(50, ha, hb);
        check(hb == 50, "R4 B steady high", hb, 50);

        // R5: width 0 and ratio 0.
        cur_req = "R5";
        wr(1, 0, 0);
        cyc(10);
        count_high(30, ha, hb);
        check(hb == 0, "R5 width zero low", hb, 0);
        wr(0, 0, 3); wr(0, 1, 0);
        cyc(40);
        count_high(30, ha, hb);
        check(ha == 30, "R5 ratio zero acts as one", ha, 30);

        // R6: disable forces low, re-enable restarts periods.
        cur_req = "R6";
        wr(0, 0, 4); wr(0, 1, 5); wr(1, 0, 3); wr(1, 1, 2);
        cyc(7);
        enable = 1'b0;
        count_high(5, ha, hb);
        check(ha == 0 && hb == 0, "R6 disabled low", ha + hb, 0);
        enable = 1'b1;
        count_high(3, ha, hb);
        check(ha == 3 && hb == 3, "R6 restart with pulse", ha + hb, 6);

        // R7: random independent settings.
        cur_req = "R7";
        for (int i = 0; i < 60; i++) begin
            int ch, wv, rv;
            ch = int'($urandom_range(0, 1));
            wv = int'($urandom_range(0, 7));
            rv = int'($urandom_range(0, 6));
            if ($urandom_range(0, 1) == 1) wr(ch, 0, wv);
            else                           wr(ch, 1, rv);
            cyc(int'($urandom_range(0, 50)));
            if ($urandom_range(0, 9) == 0) begin
                enable = 1'b0;
                cyc(int'($urandom_range(1, 3)));
                enable = 1'b1;
            end
        end

        // R8: reference settings.
        cur_req = "R8";
        enable = 1'b0;
        wr(0, 0, 250); wr(0, 1, 150); wr(1, 0, 5000); wr(1, 1, 5);
        enable = 1'b1;
        count_high(75000, ha, hb);
        check(ha == 500, "R8 A highs", ha, 500);
        check(hb == 15000, "R8 B highs", hb, 15000);

        // R9: large ratio.
        cur_req = "R9";
        enable = 1'b0;
        wr(0, 0, 2); wr(0, 1, 10000);
        enable = 1'b1;
        count_high(40000, ha, hb);
        check(ha == 4, "R9 A highs", ha, 4);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule